// File: doc/BRIEF.md
# Snoop Inquire Response and Writeback Unit

This unit answers external inquire cycles for a cache. When the system raises the inquire strobe, the unit samples the inquire address and an invalidate flag. It looks the address up in a small direct-mapped table of line tags and states, and two clocks later it reports whether the line is present (`snoop_hit`) and whether the line is dirty (`snoop_hitm`). Clean hits are downgraded right away. A dirty hit starts a four-beat writeback, which the unit hands to the bus controller.

The unit keeps answering inquires while the bus is backed off. It only asks for the bus once backoff is released. It holds the bus controller's replay of aborted processor cycles until the writeback is finished, so the writeback goes first. While a dirty hit is outstanding, the unit refuses further inquires. `snoop_hitm` stays high until the last data beat of the writeback. A simple fill port lets the cache controller install a tag and a state into the table.

Top module: `snp_inquire_unit`

## Requirements
- R1: After a synchronous active-low reset, `snoop_hit`, `snoop_hitm`, `wb_pending` and `wb_req` are low, `replay_ok` equals `!bus_backoff`, and every line is invalid, so any inquire misses.
- R2: An inquire sampled with `inq_strobe` high in cycle n produces its `snoop_hit`/`snoop_hitm` result in cycle n+2. The outputs keep the previous result in cycle n+1. The result then holds until the next accepted inquire produces its result, except as stated in R6.
- R3: The index is `inq_addr[OFS_W+IDX_W-1:OFS_W]`, the tag is the bits above it, and the offset bits below are ignored. `snoop_hit` is 1 when the indexed line has a matching tag and a state other than invalid. `snoop_hitm` is 1 only when that state is modified. On a miss both are 0.
- R4: A hit on a shared or exclusive line changes the line to invalid if `inq_inval` was 1 with the strobe, and to shared otherwise. The change takes effect at the edge that registers the result.
- R5: A hit on a modified line raises `wb_pending` in the same cycle as `snoop_hitm`. `wb_addr` then presents the snooped address until the writeback ends.
- R6: `snoop_hitm` and `wb_pending` stay high until the fourth counted `beat_ack`, and drop in the following cycle. At the edge of that fourth beat, the line becomes invalid or shared according to the stored invalidate flag.
- R7: `inq_strobe` is ignored while `snoop_hitm` is high, and also in the cycle right after an accepted inquire. An ignored inquire changes neither the outputs nor any line state.
- R8: Inquires are accepted and answered whatever the value of `bus_backoff`. `bus_backoff` may fall one cycle after the strobe without affecting the result.
- R9: `wb_req` is high exactly when a writeback is pending and `bus_backoff` is low. A `beat_ack` is counted only while `wb_req` is high.
- R10: `replay_ok` is high only when `bus_backoff` is low and no writeback is pending, so a pending writeback goes ahead of the replay of aborted cycles.
- R11: When `fill_en` is high, the line addressed by `fill_line` (index in the low `IDX_W` bits, tag above) takes that tag and the state `fill_state` at the clock edge. The state codes are 0 invalid, 1 shared, 2 exclusive, 3 modified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| inq_strobe | input | 1 | Inquire strobe from the system |
| inq_addr | input | ADDR_W | Inquire address |
| inq_inval | input | 1 | Invalidate request sampled with the strobe |
| bus_backoff | input | 1 | Bus backoff in force |
| beat_ack | input | 1 | Data beat acknowledge for the writeback |
| fill_en | input | 1 | Install a line into the table |
| fill_line | input | ADDR_W-OFS_W | Line address (tag and index) to install |
| fill_state | input | 2 | State code to install |
| snoop_hit | output | 1 | Inquire found a valid line |
| snoop_hitm | output | 1 | Inquire found a modified line; held through the writeback |
| wb_pending | output | 1 | A snoop writeback is outstanding |
| wb_req | output | 1 | Bus controller should run the writeback now |
| wb_addr | output | ADDR_W | Address of the line being written back |
| replay_ok | output | 1 | Bus controller may replay aborted cycles |

## Verification
The bench places inquires on dirty lines while backoff is held, and releases backoff one cycle after the strobe. A unit that stalled inquires during backoff, or that counted beats while the bus was backed off, would drop `snoop_hitm` too early. Such a unit would also allow a replay before the writeback finished. The bench sends inquires during a held `snoop_hitm` and in back-to-back cycles. A unit with broken masking would report a second dirty hit, or would invalidate a line it should have left alone, and later inquires on that line reveal this. The bench also checks the exact cycle of the result and the release on the fourth beat. An off-by-one stage or beat count would show as a result or a release one cycle early or late.

// File: rtl/snp_pkg.sv
// Shared types for the snoop inquire unit: line state encoding.
package snp_pkg;
    typedef enum logic [1:0] {
        LS_INV = 2'd0,
        LS_SHR = 2'd1,
        LS_EXC = 2'd2,
        LS_MOD = 2'd3
    } line_st_t;
endpackage

// File: rtl/snp_tag_table.sv
// Direct-mapped tag and state table.
// Lookup is combinational on index/tag. One update port (state only) has
// priority over the fill port (tag and state) when both hit the same line.
// Assumes the caller never updates and fills one line in the same cycle
// except where state-wins is acceptable.
module snp_tag_table
    import snp_pkg::*;
#(
    parameter int IDX_W = 3,
    parameter int TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] look_idx,
    input  logic [TAG_W-1:0] look_tag,
    output line_st_t         look_st,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0] fill_tag,
    input  line_st_t         fill_st,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  line_st_t         upd_st
);
    localparam int LINES = 1 << IDX_W;

    line_st_t   st_q  [LINES];
    logic [TAG_W-1:0] tag_q [LINES];
    logic [LINES-1:0] wr_upd;
    logic [LINES-1:0] wr_fill;

    // Per-line write decode for both ports.
    for (genvar g = 0; g < LINES; g++) begin : g_dec
        assign wr_upd[g]  = upd_en  && (upd_idx  == IDX_W'(g));
        assign wr_fill[g] = fill_en && (fill_idx == IDX_W'(g));
    end

    // Line storage: reset to invalid, update beats fill on state.
    always_ff @(posedge clk) begin
        for (int i = 0; i < LINES; i++) begin
            if (!rst_n) begin
                st_q[i]  <= LS_INV;
                tag_q[i] <= '0;
            end else if (wr_upd[i]) begin
                st_q[i] <= upd_st;
            end else if (wr_fill[i]) begin
                st_q[i]  <= fill_st;
                tag_q[i] <= fill_tag;
            end
        end
    end

    // Lookup: a tag mismatch reads as invalid.
    always_comb begin
        look_st = (tag_q[look_idx] == look_tag) ? st_q[look_idx] : LS_INV;
    end

    // R4: snoop updates only ever downgrade to invalid or shared.
    a_r4_downgrade_only: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |-> (upd_st == LS_INV || upd_st == LS_SHR));
endmodule

// File: rtl/snp_inq_pipe.sv
// Inquire sampling and response stage.
// Samples the strobe into stage 1, looks up in stage 1 and registers
// hit/hitm at the end of it (valid two clocks after the strobe). Masks the
// strobe while hitm is high or stage 1 is busy. Clean hits produce a state
// update; dirty hits start a writeback. Assumes hitm_clr comes only while
// hitm is high.
module snp_inq_pipe
    import snp_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int OFS_W  = 5,
    parameter int IDX_W  = 3,
    localparam int TAG_W = ADDR_W - OFS_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inq_strobe,
    input  logic [ADDR_W-1:0] inq_addr,
    input  logic              inq_inval,
    input  line_st_t          look_st,
    input  logic              hitm_clr,
    output logic [IDX_W-1:0]  look_idx,
    output logic [TAG_W-1:0]  look_tag,
    output logic              hit,
    output logic              hitm,
    output logic              upd_en,
    output logic [IDX_W-1:0]  upd_idx,
    output line_st_t          upd_st,
    output logic              wb_start,
    output logic [ADDR_W-1:0] wb_addr,
    output logic              wb_inv
);
    logic              s1_v;
    logic [ADDR_W-1:0] s1_addr;
    logic              s1_inv;
    logic              accept;
    logic              hit_q;
    logic              hitm_q;

    assign accept = inq_strobe && !hitm_q && !s1_v;

    // Stage 1 capture of an accepted inquire.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v    <= 1'b0;
            s1_addr <= '0;
            s1_inv  <= 1'b0;
        end else begin
            s1_v <= accept;
            if (accept) begin
                s1_addr <= inq_addr;
                s1_inv  <= inq_inval;
            end
        end
    end

    assign look_idx = s1_addr[OFS_W+IDX_W-1:OFS_W];
    assign look_tag = s1_addr[ADDR_W-1:OFS_W+IDX_W];

    // Result registers: loaded from the lookup, hitm released at writeback end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q  <= 1'b0;
            hitm_q <= 1'b0;
        end else if (s1_v) begin
            hit_q  <= (look_st != LS_INV);
            hitm_q <= (look_st == LS_MOD);
        end else if (hitm_clr) begin
            hitm_q <= 1'b0;
        end
    end

    // Clean-hit downgrade and dirty-hit writeback launch.
    always_comb begin
        upd_en   = s1_v && (look_st == LS_SHR || look_st == LS_EXC);
        upd_idx  = look_idx;
        upd_st   = s1_inv ? LS_INV : LS_SHR;
        wb_start = s1_v && (look_st == LS_MOD);
        wb_addr  = s1_addr;
        wb_inv   = s1_inv;
    end

    assign hit  = hit_q;
    assign hitm = hitm_q;

    // R3: a dirty result is always also a hit.
    a_r3_hitm_has_hit: assert property (@(posedge clk) disable iff (!rst_n)
        hitm_q |-> hit_q);
    // R6: hitm holds until the writeback end clears it.
    a_r6_hitm_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (hitm_q && !hitm_clr) |=> hitm_q);
    // R2: hitm only rises as the result of a stage-1 lookup.
    a_r2_hitm_from_lookup: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hitm_q) |-> $past(s1_v));
endmodule

// File: rtl/snp_wb_ctrl.sv
// Snoop writeback tracker.
// Holds the pending writeback, asks for the bus only outside backoff,
// counts BEATS acknowledged beats and then signals completion with the
// final state for the line. Gates replay of aborted cycles behind it.
// Assumes a new start never arrives while one is pending.
module snp_wb_ctrl
    import snp_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int OFS_W  = 5,
    parameter int IDX_W  = 3,
    parameter int BEATS  = 4,
    localparam int CNT_W = (BEATS > 2) ? $clog2(BEATS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              start_inv,
    input  logic              backoff,
    input  logic              beat_ack,
    output logic              pending,
    output logic              req,
    output logic [ADDR_W-1:0] addr,
    output logic              done,
    output logic [IDX_W-1:0]  done_idx,
    output line_st_t          done_st,
    output logic              replay_ok
);
    logic              pend_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] addr_q;
    logic              inv_q;
    logic              beat;

    assign req  = pend_q && !backoff;
    assign beat = req && beat_ack;
    assign done = beat && (cnt_q == CNT_W'(BEATS - 1));

    // Pending flag, beat counter and captured line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            cnt_q  <= '0;
            addr_q <= '0;
            inv_q  <= 1'b0;
        end else if (start) begin
            pend_q <= 1'b1;
            cnt_q  <= '0;
            addr_q <= start_addr;
            inv_q  <= start_inv;
        end else if (done) begin
            pend_q <= 1'b0;
            cnt_q  <= '0;
        end else if (beat) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Completion outputs and replay gate.
    always_comb begin
        done_idx  = addr_q[OFS_W+IDX_W-1:OFS_W];
        done_st   = inv_q ? LS_INV : LS_SHR;
        pending   = pend_q;
        addr      = addr_q;
        replay_ok = !backoff && !pend_q;
    end

    // R7: masking upstream means no writeback starts on top of another.
    a_r7_no_double_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !pend_q);
    // R6: pending holds until the final beat, then clears.
    a_r6_pend_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !done && !start) |=> pend_q);
    a_r6_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !pend_q);
endmodule

// File: rtl/snp_inquire_unit.sv
// Top of the snoop inquire response and writeback unit.
// Joins the inquire stage, the tag table and the writeback tracker; merges
// the two state-update sources (writeback end has priority; they never
// coincide because inquires are masked while a writeback is open).
module snp_inquire_unit
    import snp_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int OFS_W  = 5,
    parameter int IDX_W  = 3,
    parameter int BEATS  = 4,
    localparam int TAG_W = ADDR_W - OFS_W - IDX_W,
    localparam int LINE_W = ADDR_W - OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inq_strobe,
    input  logic [ADDR_W-1:0] inq_addr,
    input  logic              inq_inval,
    input  logic              bus_backoff,
    input  logic              beat_ack,
    input  logic              fill_en,
    input  logic [LINE_W-1:0] fill_line,
    input  logic [1:0]        fill_state,
    output logic              snoop_hit,
    output logic              snoop_hitm,
    output logic              wb_pending,
    output logic              wb_req,
    output logic [ADDR_W-1:0] wb_addr,
    output logic              replay_ok
);
    logic [IDX_W-1:0]  look_idx;
    logic [TAG_W-1:0]  look_tag;
    line_st_t          look_st;
    logic              p_upd_en;
    logic [IDX_W-1:0]  p_upd_idx;
    line_st_t          p_upd_st;
    logic              p_wb_start;
    logic [ADDR_W-1:0] p_wb_addr;
    logic              p_wb_inv;
    logic              w_done;
    logic [IDX_W-1:0]  w_done_idx;
    line_st_t          w_done_st;
    logic              t_upd_en;
    logic [IDX_W-1:0]  t_upd_idx;
    line_st_t          t_upd_st;

    snp_inq_pipe #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .IDX_W(IDX_W)) u_pipe (
        .clk        (clk),
        .rst_n      (rst_n),
        .inq_strobe (inq_strobe),
        .inq_addr   (inq_addr),
        .inq_inval  (inq_inval),
        .look_st    (look_st),
        .hitm_clr   (w_done),
        .look_idx   (look_idx),
        .look_tag   (look_tag),
        .hit        (snoop_hit),
        .hitm       (snoop_hitm),
        .upd_en     (p_upd_en),
        .upd_idx    (p_upd_idx),
        .upd_st     (p_upd_st),
        .wb_start   (p_wb_start),
        .wb_addr    (p_wb_addr),
        .wb_inv     (p_wb_inv)
    );

    // State update merge: writeback completion first.
    always_comb begin
        t_upd_en  = w_done || p_upd_en;
        t_upd_idx = w_done ? w_done_idx : p_upd_idx;
        t_upd_st  = w_done ? w_done_st  : p_upd_st;
    end

    snp_tag_table #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .look_idx (look_idx),
        .look_tag (look_tag),
        .look_st  (look_st),
        .fill_en  (fill_en),
        .fill_idx (fill_line[IDX_W-1:0]),
        .fill_tag (fill_line[LINE_W-1:IDX_W]),
        .fill_st  (line_st_t'(fill_state)),
        .upd_en   (t_upd_en),
        .upd_idx  (t_upd_idx),
        .upd_st   (t_upd_st)
    );

    snp_wb_ctrl #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .IDX_W(IDX_W), .BEATS(BEATS)) u_wb (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (p_wb_start),
        .start_addr (p_wb_addr),
        .start_inv  (p_wb_inv),
        .backoff    (bus_backoff),
        .beat_ack   (beat_ack),
        .pending    (wb_pending),
        .req        (wb_req),
        .addr       (wb_addr),
        .done       (w_done),
        .done_idx   (w_done_idx),
        .done_st    (w_done_st),
        .replay_ok  (replay_ok)
    );

    // R5: dirty-hit indication and pending writeback move together.
    a_r5_hitm_tracks_pending: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_hitm == wb_pending);
    // R10: replay is never permitted while a dirty hit is outstanding.
    a_r10_replay_after_wb: assert property (@(posedge clk) disable iff (!rst_n)
        replay_ok |-> !snoop_hitm);
endmodule

// File: tb/sim_snp_inquire_unit.sv
// Bench for snp_inquire_unit: behavioural reference model compared every
// clock, plus directed checks on the cycle-level corner cases.
module sim_snp_inquire_unit;
    localparam int AW = 16;
    localparam int OW = 5;
    localparam int IW = 3;
    localparam int LW = AW - OW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          inq_strobe = 1'b0;
    logic [AW-1:0] inq_addr = '0;
    logic          inq_inval = 1'b0;
    logic          bus_backoff = 1'b0;
    logic          beat_ack = 1'b0;
    logic          fill_en = 1'b0;
    logic [LW-1:0] fill_line = '0;
    logic [1:0]    fill_state = '0;
    logic          snoop_hit, snoop_hitm, wb_pending, wb_req, replay_ok;
    logic [AW-1:0] wb_addr;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    snp_inquire_unit u0 (
        .clk(clk), .rst_n(rst_n), .inq_strobe(inq_strobe), .inq_addr(inq_addr),
        .inq_inval(inq_inval), .bus_backoff(bus_backoff), .beat_ack(beat_ack),
        .fill_en(fill_en), .fill_line(fill_line), .fill_state(fill_state),
        .snoop_hit(snoop_hit), .snoop_hitm(snoop_hitm), .wb_pending(wb_pending),
        .wb_req(wb_req), .wb_addr(wb_addr), .replay_ok(replay_ok)
    );

    // Reference model state.
    int  m_st  [8];
    int  m_tag [8];
    bit  m_live = 0;
    bit  m_s1v, m_s1i, m_hit, m_hitm, m_pend, m_winv, m_acc, m_fire;
    int  m_s1a, m_waddr, m_widx, m_cnt, m_look, m_idx, m_fi;

    // Model: advance one clock from the inputs held across this edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) begin m_st[i] = 0; m_tag[i] = 0; end
            m_s1v = 0; m_s1i = 0; m_hit = 0; m_hitm = 0; m_pend = 0;
            m_winv = 0; m_cnt = 0; m_s1a = 0; m_waddr = 0; m_widx = 0;
            m_live = 1;
        end else begin
            m_acc = inq_strobe && !m_hitm && !m_s1v;
            m_look = 0;
            m_idx = (m_s1a >> OW) & 7;
            if (m_s1v && m_tag[m_idx] == (m_s1a >> (OW + IW))) m_look = m_st[m_idx];
            m_fire = m_pend && !bus_backoff && beat_ack && (m_cnt == 3);
            if (fill_en) begin
                m_fi = int'(fill_line) & 7;
                m_tag[m_fi] = int'(fill_line) >> IW;
                m_st[m_fi] = int'(fill_state);
            end
            if (m_fire) begin
                m_st[m_widx] = m_winv ? 0 : 1;
                m_pend = 0; m_hitm = 0; m_cnt = 0;
            end else if (m_pend && !bus_backoff && beat_ack) begin
                m_cnt++;
            end
            if (m_s1v) begin
                m_hit = (m_look != 0);
                m_hitm = (m_look == 3);
                if (m_look == 3) begin
                    m_pend = 1; m_cnt = 0; m_widx = m_idx;
                    m_winv = m_s1i; m_waddr = m_s1a;
                end else if (m_look != 0) begin
                    m_st[m_idx] = m_s1i ? 0 : 1;
                end
            end
            m_s1v = m_acc;
            if (m_acc) begin m_s1a = int'(inq_addr); m_s1i = inq_inval; end
        end
    end

    task automatic cmp(input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", what, act, exp, $time);
        end
    endtask

    // Every-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (m_live && rst_n && !finished) begin
            cmp(int'(snoop_hit),  int'(m_hit),  "R3 snoop_hit vs model");
            cmp(int'(snoop_hitm), int'(m_hitm), "R6 snoop_hitm vs model");
            cmp(int'(wb_pending), int'(m_pend), "R5 wb_pending vs model");
            cmp(int'(wb_req), int'(m_pend && !bus_backoff), "R9 wb_req vs model");
            cmp(int'(replay_ok), int'(!bus_backoff && !m_pend), "R10 replay_ok vs model");
            if (m_pend) cmp(int'(wb_addr), m_waddr, "R5 wb_addr vs model");
        end
    end

    function automatic logic [AW-1:0] mk(input int tag, input int idx, input int ofs);
        mk = {tag[7:0], idx[2:0], ofs[4:0]};
    endfunction

    task automatic cyc();
        @(posedge clk); #1;
    endtask

    task automatic fill(input logic [AW-1:0] a, input int st);
        fill_en = 1'b1; fill_line = a[AW-1:OW]; fill_state = st[1:0];
        cyc();
        fill_en = 1'b0;
    endtask

    task automatic snoop(input logic [AW-1:0] a, input logic inv);
        inq_strobe = 1'b1; inq_addr = a; inq_inval = inv;
        cyc();
        inq_strobe = 1'b0;
    endtask

    // Strobe, then wait to the cycle that carries the result and sample there.
    task automatic snoop_res(input logic [AW-1:0] a, input logic inv);
        snoop(a, inv);
        cyc();
        @(negedge clk);
    endtask

    task automatic beats(input int n);
        beat_ack = 1'b1;
        repeat (n) cyc();
        beat_ack = 1'b0;
    endtask

    task automatic chk(input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", what, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            finish_run();
        end
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        @(negedge clk);
        chk(snoop_hit,  1'b0, "R1 hit low after reset");
        chk(snoop_hitm, 1'b0, "R1 hitm low after reset");
        chk(wb_pending, 1'b0, "R1 pending low after reset");
        chk(wb_req,     1'b0, "R1 request low after reset");
        chk(replay_ok,  1'b1, "R1 replay allowed after reset");
        snoop_res(mk(0, 0, 0), 1'b0);
        chk(snoop_hit, 1'b0, "R1 empty table misses");

        // Timing and clean-hit downgrades.
        fill(mk(1, 1, 0), 2);
        snoop(mk(1, 1, 7), 1'b0);
        @(negedge clk);
        chk(snoop_hit, 1'b0, "R2 result not yet in cycle n+1");
        cyc(); @(negedge clk);
        chk(snoop_hit,  1'b1, "R2 result in cycle n+2");
        chk(snoop_hitm, 1'b0, "R3 exclusive hit gives no hitm");
        cyc(); cyc(); @(negedge clk);
        chk(snoop_hit, 1'b1, "R2 result held");
        snoop_res(mk(1, 1, 3), 1'b0);
        chk(snoop_hit, 1'b1, "R4 shared line still hits");
        snoop_res(mk(1, 1, 0), 1'b1);
        chk(snoop_hit, 1'b1, "R4 hit before invalidate");
        snoop_res(mk(1, 1, 0), 1'b0);
        chk(snoop_hit, 1'b0, "R4 line invalidated");
        fill(mk(2, 2, 0), 2);
        snoop_res(mk(3, 2, 0), 1'b0);
        chk(snoop_hit, 1'b0, "R3 tag mismatch misses");
        fill(mk(2, 3, 0), 1);
        snoop_res(mk(2, 3, 9), 1'b0);
        chk(snoop_hit, 1'b1, "R11 filled shared line hits");

        // Dirty hit, masking and writeback release.
        fill(mk(1, 3, 0), 3);
        fill(mk(1, 4, 0), 3);
        fill(mk(1, 5, 0), 1);
        snoop_res(mk(1, 3, 4), 1'b1);
        chk(snoop_hitm, 1'b1, "R5 dirty hit raises hitm");
        chk(wb_pending, 1'b1, "R5 pending with hitm");
        chk(wb_addr == mk(1, 3, 4), 1'b1, "R5 writeback address");
        snoop(mk(1, 4, 0), 1'b1);
        cyc(); cyc(); @(negedge clk);
        chk(snoop_hitm, 1'b1, "R7 hitm unchanged by masked inquire");
        beats(3);
        @(negedge clk);
        chk(snoop_hitm, 1'b1, "R6 hitm held after three beats");
        beats(1);
        @(negedge clk);
        chk(snoop_hitm, 1'b0, "R6 hitm released after final beat");
        chk(wb_pending, 1'b0, "R6 pending released after final beat");
        snoop_res(mk(1, 3, 0), 1'b0);
        chk(snoop_hit, 1'b0, "R6 line invalidated after writeback");
        snoop_res(mk(1, 4, 0), 1'b1);
        chk(snoop_hitm, 1'b1, "R7 masked inquire left line modified");
        beats(4);
        inq_strobe = 1'b1; inq_addr = mk(1, 5, 0); inq_inval = 1'b0;
        cyc();
        inq_addr = mk(1, 6, 0);
        cyc();
        inq_strobe = 1'b0;
        @(negedge clk);
        chk(snoop_hit, 1'b1, "R7 first of back-to-back hits");
        cyc(); @(negedge clk);
        chk(snoop_hit, 1'b1, "R7 second back-to-back inquire ignored");

        // Backoff interaction.
        fill(mk(1, 7, 0), 3);
        bus_backoff = 1'b1;
        snoop_res(mk(1, 7, 2), 1'b0);
        chk(snoop_hitm, 1'b1, "R8 answered during backoff");
        chk(wb_req,     1'b0, "R9 no request during backoff");
        chk(replay_ok,  1'b0, "R10 no replay during backoff");
        beats(2);
        bus_backoff = 1'b0;
        @(negedge clk);
        chk(wb_req,    1'b1, "R9 request after backoff release");
        chk(replay_ok, 1'b0, "R10 writeback ahead of replay");
        beats(3);
        @(negedge clk);
        chk(snoop_hitm, 1'b1, "R9 beats in backoff not counted");
        beats(1);
        @(negedge clk);
        chk(snoop_hitm, 1'b0, "R9 released on fourth counted beat");
        chk(replay_ok,  1'b1, "R10 replay after writeback");
        snoop_res(mk(1, 7, 0), 1'b0);
        chk(snoop_hit & ~snoop_hitm, 1'b1, "R6 line shared after writeback");
        fill(mk(2, 0, 0), 2);
        bus_backoff = 1'b1;
        snoop(mk(2, 0, 1), 1'b0);
        bus_backoff = 1'b0;
        cyc(); @(negedge clk);
        chk(snoop_hit, 1'b1, "R8 backoff released one clock after strobe");

        // Mixed traffic against the model.
        for (int k = 0; k < 4000; k++) begin
            inq_strobe = ($urandom % 4) == 0;
            inq_addr = mk(int'($urandom % 2) + 1, int'($urandom % 8), int'($urandom % 32));
            inq_inval = $urandom % 2;
            if (($urandom % 8) == 0) bus_backoff = ~bus_backoff;
            beat_ack = $urandom % 2;
            fill_en = !m_s1v && !m_pend && (($urandom % 6) == 0);
            fill_line = LW'({($urandom % 2) + 1, $urandom % 8} & 32'hF);
            fill_line = {3'b0, 5'(($urandom % 2) + 1), 3'($urandom % 8)};
            fill_state = 2'($urandom % 4);
            cyc();
        end
        inq_strobe = 1'b0; fill_en = 1'b0; bus_backoff = 1'b0;
        for (int k = 0; k < 20 && m_pend; k++) begin
            beat_ack = 1'b1;
            cyc();
        end
        beat_ack = 1'b0;
        cyc(); @(negedge clk);
        chk(wb_pending, 1'b0, "R6 all writebacks drained");
        finish_run();
    end
endmodule